// File: doc/BRIEF.md
# BCH syndrome expansion unit

This unit turns the odd-indexed partial syndrome words of one BCH-protected sector into the complete list of 2t syndromes over GF(2^m). The caller chooses the sector size and the correction strength with each start. A 1 KiB sector selects the degree-14 field, and a 512-byte sector selects the degree-13 field. The unit then works alone. It accumulates each odd syndrome one partial-syndrome bit per cycle. After that it derives every even syndrome by squaring a syndrome of lower index that it has already computed.

The field arithmetic uses a GF(2^m) multiplier built from logic, with a fixed primitive polynomial for each degree. No logarithm or antilogarithm tables are stored. A zero syndrome therefore squares to zero without any special case. All results stay readable on a flat output bus until the next accepted start. A one-cycle done pulse marks completion. The error-locator solver that follows reads this bus.

Top module: `bch_syndrome_expander`

## Requirements
- R1: During and right after synchronous reset, busy_o and done_o are low and every syndrome slot of syn_o reads zero.
- R2: With m = 13 (sec1k_i = 0, alpha a root of x^13+x^4+x^3+x+1) or m = 14 (sec1k_i = 1, alpha a root of x^14+x^10+x^6+x+1), each odd syndrome S_i, i = 2k+1 < 2t, equals the XOR of alpha^((i*j) mod (2^m-1)) over every bit j < m that is set in partial word k.
- R3: For j = 1..t, S_2j equals S_j squared in the same field.
- R4: When S_j is zero, S_2j is zero.
- R5: capsel_i selects t: 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 12, 4 gives 24, and 5 to 7 give 2. Partial words k >= t are ignored, and syndrome slots at or above 2t read zero after the run.
- R6: Partial word k sits at psyn_i[k*14 +: 14]. Syndrome S_s (s = 1..48) sits at syn_o[(s-1)*14 +: 14]. When m = 13, bit 13 of each partial word is ignored and bit 13 of each syndrome is zero.
- R7: A start seen at a clock edge while idle is accepted. busy_o is high from the next cycle. done_o is a one-cycle pulse that shows in the cycle after the t*(m+1)-th edge following the accepting edge, and busy_o stays high through that cycle.
- R8: A start asserted while busy_o is high is ignored, together with the configuration and partial words presented with it. Neither results nor timing change.
- R9: Once a run is over and no start is accepted, syn_o holds its values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run (taken only when idle) |
| sec1k_i | input | 1 | 0: 512-byte sector, m = 13; 1: 1 KiB sector, m = 14 |
| capsel_i | input | 3 | Correction strength code |
| psyn_i | input | 336 | 24 partial words of 14 bits, word k for syndrome index 2k+1 |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| syn_o | output | 672 | 48 syndrome slots of 14 bits |

## Verification
A wrong accumulator, power or alpha-step register corrupts one odd syndrome, and every even syndrome that squares from it inherits the error. Comparing all 48 slots against a table-based field model shows the fault at the done pulse of the first run whose partial bits reach that state. A wrong index counter or phase change shows up directly as a latency that differs from t*(m+1). A missed slot clear shows up as stale data above 2t, visible in the first short run that follows a long one.

// File: rtl/bch_syn_pkg.sv
package bch_syn_pkg;

    parameter int MAXM  = 14;
    parameter int MAXT  = 24;
    localparam int NSYN = 2 * MAXT;
    localparam int IDXW = $clog2(NSYN);
    localparam int KW   = $clog2(MAXT + 1);
    localparam int JW   = $clog2(MAXM);

    typedef logic [MAXM-1:0] gf_t;

    localparam gf_t POLY_LO = gf_t'(14'h001B);
    localparam gf_t POLY_HI = gf_t'(14'h0443);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ODD,
        PH_EVEN,
        PH_FIN
    } phase_e;

    typedef struct packed {
        logic          deg14;
        logic [KW-1:0] tcap;
    } cfg_t;

    function automatic logic [KW-1:0] cap_of(input logic [2:0] sel);
        case (sel)
            3'd1:    return KW'(4);
            3'd2:    return KW'(8);
            3'd3:    return KW'(12);
            3'd4:    return KW'(24);
            default: return KW'(2);
        endcase
    endfunction

    function automatic gf_t gf_xtime(input gf_t x, input logic deg14);
        gf_t  r;
        logic top;
        top = deg14 ? x[MAXM-1] : x[MAXM-2];
        r   = {x[MAXM-2:0], 1'b0};
        if (!deg14) r[MAXM-1] = 1'b0;
        if (top) r = r ^ (deg14 ? POLY_HI : POLY_LO);
        return r;
    endfunction

    function automatic gf_t gf_mult(input gf_t a, input gf_t b, input logic deg14);
        gf_t r;
        r = '0;
        for (int bi = MAXM - 1; bi >= 0; bi--) begin
            r = gf_xtime(r, deg14);
            if (b[bi]) r = r ^ a;
        end
        return r;
    endfunction

endpackage

// File: rtl/gf_mul_unit.sv
module gf_mul_unit
    import bch_syn_pkg::*;
(
    input  gf_t  a_i,
    input  gf_t  b_i,
    input  logic deg14_i,
    output gf_t  p_o
);
    assign p_o = gf_mult(a_i, b_i, deg14_i);
endmodule

// File: rtl/syn_store.sv
module syn_store
    import bch_syn_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr_i,
    input  logic                 wr_en_i,
    input  logic [IDXW-1:0]      wr_idx_i,
    input  gf_t                  wr_data_i,
    input  logic [IDXW-1:0]      rd_idx_i,
    output gf_t                  rd_data_o,
    output logic [NSYN*MAXM-1:0] flat_o
);
    gf_t slot_q [NSYN];

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            for (int s = 0; s < NSYN; s++) slot_q[s] <= '0;
        end else if (wr_en_i) begin
            slot_q[wr_idx_i] <= wr_data_i;
        end
    end

    assign rd_data_o = slot_q[rd_idx_i];

    for (genvar g = 0; g < NSYN; g++) begin : g_flat
        assign flat_o[g*MAXM +: MAXM] = slot_q[g];
    end
endmodule

// File: rtl/syn_ctrl.sv
module syn_ctrl
    import bch_syn_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic                 sec1k_i,
    input  logic [2:0]           capsel_i,
    input  logic [MAXT*MAXM-1:0] psyn_i,
    input  gf_t                  pw_next_i,
    input  gf_t                  beta_next_i,
    input  gf_t                  sq_i,
    output gf_t                  pw_o,
    output gf_t                  beta_o,
    output cfg_t                 cfg_o,
    output logic                 clr_o,
    output logic                 wr_en_o,
    output logic [IDXW-1:0]      wr_idx_o,
    output gf_t                  wr_data_o,
    output logic [IDXW-1:0]      rd_idx_o,
    output logic                 even_o,
    output logic                 busy_o,
    output logic                 done_o
);
    phase_e        ph_q;
    cfg_t          cfg_q;
    logic [KW-1:0] k_q;
    logic [JW-1:0] j_q;
    logic [KW-1:0] j2_q;
    gf_t           acc_q;
    gf_t           pw_q;
    gf_t           beta_q;
    gf_t           part_q [MAXT];

    logic          bit_now;
    logic          last_j;
    gf_t           acc_fin;

    assign bit_now = part_q[k_q][j_q];
    assign last_j  = (j_q == (cfg_q.deg14 ? JW'(MAXM - 1) : JW'(MAXM - 2)));
    assign acc_fin = acc_q ^ (bit_now ? pw_q : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            cfg_q  <= '0;
            k_q    <= '0;
            j_q    <= '0;
            j2_q   <= '0;
            acc_q  <= '0;
            pw_q   <= '0;
            beta_q <= '0;
            for (int s = 0; s < MAXT; s++) part_q[s] <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (start_i) begin
                        cfg_q.deg14 <= sec1k_i;
                        cfg_q.tcap  <= cap_of(capsel_i);
                        for (int s = 0; s < MAXT; s++)
                            part_q[s] <= psyn_i[s*MAXM +: MAXM];
                        k_q    <= '0;
                        j_q    <= '0;
                        acc_q  <= '0;
                        pw_q   <= gf_t'(1);
                        beta_q <= gf_t'(2);
                        ph_q   <= PH_ODD;
                    end
                end
                PH_ODD: begin
                    if (last_j) begin
                        j_q    <= '0;
                        acc_q  <= '0;
                        pw_q   <= gf_t'(1);
                        beta_q <= beta_next_i;
                        k_q    <= k_q + 1'b1;
                        if (k_q == KW'(cfg_q.tcap - 1'b1)) begin
                            ph_q <= PH_EVEN;
                            j2_q <= KW'(1);
                        end
                    end else begin
                        j_q   <= j_q + 1'b1;
                        acc_q <= acc_fin;
                        pw_q  <= pw_next_i;
                    end
                end
                PH_EVEN: begin
                    j2_q <= j2_q + 1'b1;
                    if (j2_q == cfg_q.tcap) ph_q <= PH_FIN;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        clr_o     = (ph_q == PH_IDLE) && start_i;
        wr_en_o   = ((ph_q == PH_ODD) && last_j) || (ph_q == PH_EVEN);
        wr_idx_o  = (ph_q == PH_ODD) ? IDXW'({k_q, 1'b0})
                                     : IDXW'({j2_q, 1'b0} - 1'b1);
        wr_data_o = (ph_q == PH_ODD) ? acc_fin : sq_i;
        rd_idx_o  = IDXW'(j2_q - 1'b1);
    end

    assign pw_o   = pw_q;
    assign beta_o = beta_q;
    assign cfg_o  = cfg_q;
    assign even_o = (ph_q == PH_EVEN);
    assign busy_o = (ph_q != PH_IDLE);
    assign done_o = (ph_q == PH_FIN);
endmodule

// File: rtl/bch_syndrome_expander.sv
module bch_syndrome_expander
    import bch_syn_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic                 sec1k_i,
    input  logic [2:0]           capsel_i,
    input  logic [MAXT*MAXM-1:0] psyn_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [NSYN*MAXM-1:0] syn_o
);
    localparam int NMUL = 3;

    gf_t             pw, beta, pw_next, beta_next, sq;
    gf_t             rd_data, wr_data;
    cfg_t            cfg_q;
    logic            clr, wr_en, even_ph;
    logic [IDXW-1:0] wr_idx, rd_idx;

    gf_t mul_a [NMUL];
    gf_t mul_b [NMUL];
    gf_t mul_p [NMUL];

    assign mul_a[0] = pw;      assign mul_b[0] = beta;
    assign mul_a[1] = beta;    assign mul_b[1] = gf_t'(4);
    assign mul_a[2] = rd_data; assign mul_b[2] = rd_data;

    for (genvar g = 0; g < NMUL; g++) begin : g_mul
        gf_mul_unit u_mul (
            .a_i     (mul_a[g]),
            .b_i     (mul_b[g]),
            .deg14_i (cfg_q.deg14),
            .p_o     (mul_p[g])
        );
    end

    assign pw_next   = mul_p[0];
    assign beta_next = mul_p[1];
    assign sq        = mul_p[2];

    syn_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .sec1k_i     (sec1k_i),
        .capsel_i    (capsel_i),
        .psyn_i      (psyn_i),
        .pw_next_i   (pw_next),
        .beta_next_i (beta_next),
        .sq_i        (sq),
        .pw_o        (pw),
        .beta_o      (beta),
        .cfg_o       (cfg_q),
        .clr_o       (clr),
        .wr_en_o     (wr_en),
        .wr_idx_o    (wr_idx),
        .wr_data_o   (wr_data),
        .rd_idx_o    (rd_idx),
        .even_o      (even_ph),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    syn_store u_store (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (clr),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data),
        .flat_o    (syn_o)
    );
endmodule

// File: rtl/syn_expander_chk.sv
module syn_expander_chk
    import bch_syn_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic [NSYN*MAXM-1:0] syn,
    input cfg_t                 cfg_q,
    input logic                 wr_en,
    input gf_t                  wr_data,
    input gf_t                  sq_src,
    input logic                 even_ph
);
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_done_in_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    a_r7_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg_q));

    a_r4_zero_square: assert property (@(posedge clk) disable iff (rst)
        (even_ph && wr_en && (sq_src == '0)) |-> (wr_data == '0));

    a_r9_results_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(syn));
endmodule

bind bch_syndrome_expander syn_expander_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start_i),
    .busy    (busy_o),
    .done    (done_o),
    .syn     (syn_o),
    .cfg_q   (cfg_q),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .sq_src  (rd_data),
    .even_ph (even_ph)
);

// File: tb/bch_syndrome_expander_tb_top.sv
module bch_syndrome_expander_tb_top;
    import bch_syn_pkg::*;

    localparam int PW = MAXT * MAXM;
    localparam int SW = NSYN * MAXM;

    logic          clk = 1'b0;
    logic          rst;
    logic          start_i;
    logic          sec1k_i;
    logic [2:0]    capsel_i;
    logic [PW-1:0] psyn_i;
    logic          busy_o, done_o;
    logic [SW-1:0] syn_o;

    always #5 clk = ~clk;

    bch_syndrome_expander dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .sec1k_i(sec1k_i),
        .capsel_i(capsel_i), .psyn_i(psyn_i),
        .busy_o(busy_o), .done_o(done_o), .syn_o(syn_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int alog [2][16384];
    int lg   [2][16384];
    int expv [NSYN];

    // deg (1) | capsel (3) | seed (16)
    localparam logic [19:0] VEC [10] = '{
        {1'b0, 3'd0, 16'h1234}, {1'b1, 3'd0, 16'hBEEF},
        {1'b0, 3'd1, 16'h0F0F}, {1'b1, 3'd1, 16'h5A5A},
        {1'b0, 3'd2, 16'hC001}, {1'b1, 3'd2, 16'h7777},
        {1'b0, 3'd3, 16'h2468}, {1'b1, 3'd3, 16'h1357},
        {1'b0, 3'd4, 16'hA5A5}, {1'b1, 3'd4, 16'h0042}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int tval(input logic [2:0] sel);
        case (sel)
            3'd1: return 4;
            3'd2: return 8;
            3'd3: return 12;
            3'd4: return 24;
            default: return 2;
        endcase
    endfunction

    function automatic logic [PW-1:0] mk_ps(input int seed);
        logic [31:0]   s;
        logic [PW-1:0] r;
        s = 32'(seed) ^ 32'h9E3779B9;
        for (int k = 0; k < MAXT; k++) begin
            s = s ^ (s << 13);
            s = s ^ (s >> 17);
            s = s ^ (s << 5);
            r[k*MAXM +: MAXM] = s[MAXM-1:0];
        end
        return r;
    endfunction

    task automatic build_tables();
        for (int d = 0; d < 2; d++) begin
            int m = 13 + d;
            int n = (1 << m) - 1;
            int poly = d ? 'h4443 : 'h201B;
            int x = 1;
            for (int e = 0; e < n; e++) begin
                alog[d][e] = x;
                lg[d][x]   = e;
                x = x << 1;
                if ((x >> m) & 1) x = x ^ poly;
            end
        end
    endtask

    task automatic model(input logic deg, input int t, input logic [PW-1:0] ps);
        int d = deg ? 1 : 0;
        int m = 13 + d;
        int n = (1 << m) - 1;
        for (int s = 0; s < NSYN; s++) expv[s] = 0;
        for (int k = 0; k < t; k++) begin
            int i = 2 * k + 1;
            int acc = 0;
            for (int j = 0; j < m; j++)
                if (ps[k*MAXM + j]) acc = acc ^ alog[d][(i * j) % n];
            expv[i-1] = acc;
        end
        for (int j = 1; j <= t; j++)
            expv[2*j-1] = (expv[j-1] == 0) ? 0 : alog[d][(2 * lg[d][expv[j-1]]) % n];
    endtask

    function automatic int slot(input int s);
        return int'(syn_o[s*MAXM +: MAXM]);
    endfunction

    task automatic run(input logic deg, input logic [2:0] sel,
                       input logic [PW-1:0] ps, input bit inj, input string tag);
        int t = tval(sel);
        int cnt = 0;
        int lat_exp = t * (14 + (deg ? 1 : 0) - 1 + 1) + 1;
        model(deg, t, ps);
        @(negedge clk);
        sec1k_i = deg; capsel_i = sel; psyn_i = ps; start_i = 1'b1;
        do begin
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
            cnt++;
            if (inj && cnt == 5) begin
                start_i = 1'b1; sec1k_i = ~deg; capsel_i = 3'd4; psyn_i = ~ps;
            end
        end while (!done_o && cnt < 2000);
        chk(cnt == lat_exp, {"R7 latency ", tag}, cnt, lat_exp);
        for (int s = 0; s < NSYN; s++) begin
            string rq = (s >= 2 * t) ? "R5 slot" : ((s % 2 == 0) ? "R2 odd" : "R3 even");
            chk(slot(s) == expv[s], $sformatf("%s S%0d %s", rq, s + 1, tag), slot(s), expv[s]);
        end
        @(negedge clk);
        chk(!done_o && !busy_o, {"R7 done pulse ends ", tag}, int'(done_o), 0);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [PW-1:0] ps;
        logic [SW-1:0] held;
        build_tables();
        rst = 1'b1; start_i = 1'b0; sec1k_i = 1'b0; capsel_i = '0; psyn_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy_o && !done_o, "R1 flags in reset", int'(busy_o), 0);
        chk(syn_o == '0, "R1 slots in reset", int'(syn_o != '0), 0);
        rst = 1'b0;

        for (int v = 0; v < 10; v++)
            run(VEC[v][19], VEC[v][18:16], mk_ps(int'(VEC[v][15:0])), 1'b0,
                $sformatf("vec%0d", v));

        // R2: single bit j=1 in word 0, m=14: S1=alpha, S2=alpha^2, S4=alpha^4
        ps = '0; ps[1] = 1'b1;
        run(1'b1, 3'd0, ps, 1'b0, "single bit");
        chk(slot(0) == 2,  "R2 S1 literal", slot(0), 2);
        chk(slot(1) == 4,  "R3 S2 literal", slot(1), 4);
        chk(slot(3) == 16, "R3 S4 literal", slot(3), 16);

        // R4: all-zero partials
        run(1'b0, 3'd2, '0, 1'b0, "all zero");
        chk(syn_o == '0, "R4 all zero", int'(syn_o != '0), 0);

        // R4: word 1 (S3) zero forces S6 zero
        ps = mk_ps(99); ps[1*MAXM +: MAXM] = '0;
        run(1'b0, 3'd1, ps, 1'b0, "S3 zero");
        chk(slot(5) == 0, "R4 S6 from zero S3", slot(5), 0);

        // R6: bit 13 ignored for m=13
        ps = mk_ps(7);
        for (int k = 0; k < MAXT; k++) ps[k*MAXM + 13] = 1'b1;
        run(1'b0, 3'd3, ps, 1'b0, "bit13 set");
        for (int s = 0; s < NSYN; s++)
            chk(syn_o[s*MAXM + 13] == 1'b0, "R6 top bit zero", int'(syn_o[s*MAXM + 13]), 0);

        // R5: codes 5..7 give t=2, stale long-run slots cleared
        run(1'b1, 3'd4, mk_ps(321), 1'b0, "long before short");
        run(1'b1, 3'd6, mk_ps(55), 1'b0, "capsel6");

        // R8: start during a run ignored
        run(1'b0, 3'd2, mk_ps(808), 1'b1, "R8 start while busy");

        // R9: results held while idle
        held = syn_o;
        @(negedge clk);
        sec1k_i = 1'b1; capsel_i = 3'd4; psyn_i = ~psyn_i;
        repeat (10) @(negedge clk);
        chk(syn_o == held, "R9 hold while idle", int'(syn_o != held), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule